// File: doc/BRIEF.md
# Stereo PDM Decimation Filter

This block turns two 1-bit pulse density streams, left and right, into signed 20-bit PCM words. Each stream carries one bit per PDM clock. The capture logic in front of the block has already split the shared data line into two bits, one taken on each edge of the PDM clock. The block sees that clock as a one-cycle enable, `pdm_en_i`, and samples both bits on every enable.

Both channels run through the same filter path, and all of it is clocked by the enable:

1. Each bit maps to +1 (for a 1) or -1 (for a 0).
2. A fourth-order cascaded integrator-comb filter decimates by 64.
3. A three-tap compensation FIR with unity DC gain follows.
4. An arithmetic shift and a saturation stage bring the result into the 20-bit range.

One pair of PCM words comes out for every 64 enables, marked by a single-cycle strobe. The words hold their value until the next strobe. After reset no strobe is issued until every stage holds valid history.

Top module: `pdm_decim_top`

## Requirements
- R1: After the filter has filled, `pcm_valid_o` pulses exactly once per 64 accepted enables, and each pulse lasts one clock cycle.
- R2: Take an input that repeats with period P, where P divides 64 and each period holds k ones. The settled output is (2k-P)*2^19/P, and it saturates at +524287.
- R3: A steady all-ones input settles at +524287, the most positive 20-bit code. A steady all-zeros input settles at -524288, the most negative code.
- R4: An alternating 1/0 input settles at exactly 0.
- R5: `pcm_left_o` depends only on `left_bit_i`, and `pcm_right_o` depends only on `right_bit_i`.
- R6: After reset, the first strobe follows the 448th enable, which is the seventh decimation point. It comes no earlier than that and at most four clocks later. Its sample is already settled, so an all-ones input from reset gives +524287 on the first strobe.
- R7: Clocks with `pdm_en_i` low change no state. The input bits are ignored on those clocks, and idle gaps between enables leave the results unchanged.
- R8: Between strobes, both PCM outputs hold their value.
- R9: Asserting `rst_ni` low clears all filter state. It also forces the strobe low and both PCM outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdm_en_i | input | 1 | One pulse per PDM clock; qualifies both input bits |
| left_bit_i | input | 1 | Left-channel PDM bit |
| right_bit_i | input | 1 | Right-channel PDM bit |
| pcm_valid_o | output | 1 | One-cycle strobe for a new sample pair |
| pcm_left_o | output | 20 | Signed left PCM sample |
| pcm_right_o | output | 20 | Signed right PCM sample |

## Verification
The hardest condition to reach from the ports is an exact, known output value, because it depends on a history of about 450 input bits across four integrators, four combs and three FIR taps. The stimulus uses periodic bit patterns whose period divides 64. Every 64-bit window of such a pattern has the same sum regardless of phase, so once the filter settles its output is a closed-form multiple of 2^16 or finer. The bench therefore waits a dozen frames after each pattern change and then compares every strobe in a measurement window against that value. The same patterns are repeated with idle gaps and with random bits on the idle cycles. Two moments are checked separately: the exact point of the first strobe after reset and after a reset mid-stream.

// File: rtl/pdm_decim_pkg.sv
package pdm_decim_pkg;
  localparam int unsigned DECIM_DEF = 64;
  localparam int unsigned ORDER_DEF = 4;
  localparam int unsigned PCM_W_DEF = 20;
  localparam int unsigned FIR_GAIN_LOG2 = 3;  // 10*x1 - x0 - x2 sums to 8
endpackage

// File: rtl/pdm_decim_ctrl.sv
module pdm_decim_ctrl #(
  parameter int unsigned DECIM = 64,
  parameter int unsigned FILL  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic fill_done_o
);
  localparam int unsigned CNT_W  = $clog2(DECIM);
  localparam int unsigned FILL_W = $clog2(FILL + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [FILL_W-1:0] fill_q;

  assign tick_o      = en_i && (cnt_q == CNT_W'(DECIM - 1));
  assign fill_done_o = (fill_q == FILL_W'(FILL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fill_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (tick_o && !fill_done_o) fill_q <= fill_q + 1'b1;
    end
  end

  a_r1_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(fill_q)));
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int unsigned ORDER = 4,
  parameter int unsigned ACC_W = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] stage_q [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [ACC_W-1:0] add_in;
    logic signed [ACC_W-1:0] sum_q;
    if (s == 0) begin : g_first
      assign add_in = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};
    end else begin : g_next
      assign add_in = stage_q[s-1];
    end
    // wrap-around accumulation; the combs cancel the overflow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sum_q <= '0;
      else if (en_i) sum_q <= sum_q + add_in;
    end
    assign stage_q[s] = sum_q;
  end

  assign acc_o = stage_q[ORDER-1];

  a_r7_integ_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int unsigned ORDER = 4,
  parameter int unsigned ACC_W = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] out_o,
  output logic                    valid_o
);
  localparam logic signed [ACC_W-1:0] LIM = ACC_W'(1) <<< (ACC_W - 2);

  logic signed [ACC_W-1:0] diff [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [ACC_W-1:0] din;
    logic signed [ACC_W-1:0] dly_q;
    if (s == 0) begin : g_first
      assign din = acc_i;
    end else begin : g_next
      assign din = diff[s-1];
    end
    assign diff[s] = din - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q <= '0;
      else if (tick_i) dly_q <= din;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) out_o <= diff[ORDER-1];
    end
  end

  a_r2_cic_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((out_o <= LIM) && (out_o >= -LIM)));
endmodule

// File: rtl/comp_fir.sv
module comp_fir #(
  parameter int unsigned ACC_W = 26,
  parameter int unsigned PCM_W = 20,
  parameter int unsigned SHIFT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [ACC_W-1:0] in_i,
  input  logic                    allow_i,
  output logic signed [PCM_W-1:0] pcm_o,
  output logic                    valid_o
);
  localparam int unsigned SUM_W = ACC_W + 4;
  localparam logic signed [SUM_W-1:0] P_MAX = (SUM_W'(1) <<< (PCM_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] P_MIN = -P_MAX - SUM_W'(1);

  logic signed [ACC_W-1:0] x1_q, x2_q;
  logic signed [SUM_W-1:0] e_new, e_mid, e_old, sum, shifted;
  logic signed [PCM_W-1:0] pcm_d;
  logic                    sat_hi, sat_lo;

  assign e_new   = SUM_W'(in_i);
  assign e_mid   = SUM_W'(x1_q);
  assign e_old   = SUM_W'(x2_q);
  // taps -1, 10, -1
  assign sum     = (e_mid <<< 3) + (e_mid <<< 1) - e_new - e_old;
  assign shifted = sum >>> SHIFT;
  assign sat_hi  = shifted > P_MAX;
  assign sat_lo  = shifted < P_MIN;
  assign pcm_d   = sat_hi ? PCM_W'(P_MAX) : sat_lo ? PCM_W'(P_MIN) : shifted[PCM_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q    <= '0;
      x2_q    <= '0;
      pcm_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= in_valid_i && allow_i;
      if (in_valid_i) begin
        x1_q <= in_i;
        x2_q <= x1_q;
        if (allow_i) pcm_o <= pcm_d;
      end
    end
  end

  a_r1_fir_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(in_valid_i));
  a_r8_fir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pcm_o));
endmodule

// File: rtl/pdm_decim_top.sv
module pdm_decim_top
  import pdm_decim_pkg::*;
#(
  parameter int unsigned DECIM = DECIM_DEF,
  parameter int unsigned ORDER = ORDER_DEF,
  parameter int unsigned PCM_W = PCM_W_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pdm_en_i,
  input  logic                    left_bit_i,
  input  logic                    right_bit_i,
  output logic                    pcm_valid_o,
  output logic signed [PCM_W-1:0] pcm_left_o,
  output logic signed [PCM_W-1:0] pcm_right_o
);
  localparam int unsigned ACC_W = 2 + ORDER * $clog2(DECIM);
  localparam int unsigned SHIFT = (ACC_W - 2) - (PCM_W - 1) + FIR_GAIN_LOG2;
  localparam int unsigned FILL  = ORDER + 3;
  localparam int unsigned NCH   = 2;

  logic                    tick, fill_done;
  logic [NCH-1:0]          ch_bit, ch_valid;
  logic signed [PCM_W-1:0] ch_pcm [NCH];

  assign ch_bit = {right_bit_i, left_bit_i};

  pdm_decim_ctrl #(.DECIM(DECIM), .FILL(FILL)) u_ctrl (
    .clk_i, .rst_ni, .en_i(pdm_en_i), .tick_o(tick), .fill_done_o(fill_done)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [ACC_W-1:0] acc, cic;
    logic                    cic_v;
    cic_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk_i, .rst_ni, .en_i(pdm_en_i), .bit_i(ch_bit[c]), .acc_o(acc)
    );
    cic_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
      .clk_i, .rst_ni, .tick_i(tick), .acc_i(acc), .out_o(cic), .valid_o(cic_v)
    );
    comp_fir #(.ACC_W(ACC_W), .PCM_W(PCM_W), .SHIFT(SHIFT)) u_fir (
      .clk_i, .rst_ni, .in_valid_i(cic_v), .in_i(cic), .allow_i(fill_done),
      .pcm_o(ch_pcm[c]), .valid_o(ch_valid[c])
    );
  end

  assign pcm_valid_o = ch_valid[0];
  assign pcm_left_o  = ch_pcm[0];
  assign pcm_right_o = ch_pcm[1];

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |=> !pcm_valid_o);
  a_r5_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid[0] == ch_valid[1]);
  a_r6_no_early_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_done |=> !pcm_valid_o);
  a_r8_hold_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcm_valid_o |-> $stable(pcm_right_o));
endmodule

// File: tb/pdm_decim_top_bench.sv
`timescale 1ns/1ps
module pdm_decim_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, lbit = 1'b0, rbit = 1'b0;
  logic pcm_valid;
  logic signed [19:0] pcm_l, pcm_r;

  pdm_decim_top u_pdm_decim_top (
    .clk_i(clk), .rst_ni(rst_n), .pdm_en_i(en), .left_bit_i(lbit), .right_bit_i(rbit),
    .pcm_valid_o(pcm_valid), .pcm_left_o(pcm_l), .pcm_right_o(pcm_r)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int bit_idx = 0, gap_n = 0;
  int lp = 1, lk = 1, rp = 1, rk = 0;
  int vcount = 0, exp_l = 0, exp_r = 0, hold_err = 0;
  bit arm = 0;
  string cur_tag = "";
  logic signed [19:0] prev_l = '0, prev_r = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int expect_of(input int p, input int k);
    int v = ((2 * k - p) * 524288) / p;
    if (v > 524287) v = 524287;
    return v;
  endfunction

  // monitor: per-strobe comparison and R8 hold tracking
  always @(negedge clk) begin
    if (rst_n) begin
      if (pcm_valid) begin
        vcount++;
        if (arm) begin
          chk(pcm_l == exp_l, {cur_tag, " left"}, pcm_l, exp_l);
          chk(pcm_r == exp_r, {cur_tag, " right"}, pcm_r, exp_r);
        end
      end else if (pcm_l != prev_l || pcm_r != prev_r) begin
        hold_err++;
      end
      prev_l = pcm_l;
      prev_r = pcm_r;
    end
  end

  task automatic drive(input bit e);
    @(negedge clk);
    en = e;
    if (e) begin
      lbit = (bit_idx % lp) < lk;
      rbit = (bit_idx % rp) < rk;
      bit_idx++;
    end else begin
      lbit = 1'($urandom);
      rbit = 1'($urandom);
    end
  endtask

  task automatic run_en(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1);
      for (int g = 0; g < gap_n; g++) drive(1'b0);
    end
  endtask

  task automatic measure(input int alp, input int alk, input int arp, input int ark, input string tag);
    lp = alp; lk = alk; rp = arp; rk = ark;
    run_en(12 * 64);
    for (int i = 0; i < 3; i++) drive(1'b0);
    exp_l = expect_of(alp, alk);
    exp_r = expect_of(arp, ark);
    cur_tag = tag;
    vcount = 0;
    arm = 1;
    run_en(4 * 64);
    for (int i = 0; i < 3; i++) drive(1'b0);
    arm = 0;
    chk(vcount == 4, {tag, " R1 strobes per 256 enables"}, vcount, 4);
  endtask

  task automatic first_strobe(input string tag);
    int n = 0;
    bit seen = 0;
    lp = 1; lk = 1; rp = 1; rk = 0;
    rst_n = 1'b1;
    bit_idx = 0;
    while (!seen && n < 600) begin
      drive(1'b1);
      n++;
      #1;
      if (pcm_valid) seen = 1;
    end
    chk(n >= 448 && n <= 452, {tag, " R6 first strobe enable index"}, n, 450);
    chk(pcm_l == 524287, {tag, " R6 R3 first left settled"}, pcm_l, 524287);
    chk(pcm_r == -524288, {tag, " R6 R3 first right settled"}, pcm_r, -524288);
    while (bit_idx % 64 != 0) drive(1'b1);
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    checks++;
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic signed [19:0] keep_l, keep_r;
    int keep_v;
    lbit = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(pcm_valid == 1'b0, "R9 reset valid", pcm_valid, 0);
    chk(pcm_l == 0 && pcm_r == 0, "R9 reset outputs", pcm_l, 0);

    first_strobe("initial");

    measure(1, 1, 1, 0, "R3 ones/zeros");
    measure(1, 0, 1, 1, "R3 R5 zeros/ones");
    measure(2, 1, 2, 1, "R4 alternating");
    measure(2, 1, 1, 1, "R4 R5 alt/ones");
    for (int k = 0; k <= 8; k++) measure(8, k, 8, 8 - k, $sformatf("R2 R5 p8 k%0d", k));
    measure(64, 1, 64, 63, "R2 p64");
    measure(16, 5, 32, 7, "R2 p16/p32");

    gap_n = 2;
    measure(8, 3, 4, 1, "R7 gapped");
    measure(2, 1, 1, 0, "R7 R4 gapped");
    gap_n = 0;

    keep_l = pcm_l; keep_r = pcm_r; keep_v = vcount;
    for (int i = 0; i < 300; i++) drive(1'b0);
    chk(vcount == keep_v, "R7 no strobe while idle", vcount, keep_v);
    chk(pcm_l == keep_l && pcm_r == keep_r, "R7 idle outputs held", pcm_l, keep_l);
    measure(2, 1, 1, 0, "R7 resume after idle");

    chk(hold_err == 0, "R8 outputs held between strobes", hold_err, 0);

    lp = 8; lk = 5; rp = 4; rk = 3;
    run_en(100);
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(pcm_valid == 1'b0, "R9 midstream valid", pcm_valid, 0);
    chk(pcm_l == 0 && pcm_r == 0, "R9 midstream outputs", pcm_r, 0);
    lbit = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    first_strobe("after reset");
    measure(4, 1, 4, 3, "R2 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule